// File: doc/BRIEF.md
# S/PDIF Receiver Phase Controller

This block steers a biphase-mark audio receiver through its three operating phases: idle, synchronization and reception. Software drives a 2-bit enable code, a 2-bit retry-budget code, a wait-for-activity option and a 2-bit line selector. The controller watches the selected serial line for transitions. It launches synchronization attempts through a simple handshake with an external synchronizer, and it reports the phase it is in, a one-cycle completion event and a sticky failure flag.

The synchronizer itself is outside this block. The controller pulses `att_start` to begin one attempt. The synchronizer later answers with a one-cycle `att_ok` or `att_fail`. Only one attempt is outstanding at a time. No data stream passes through the block, so every pin is a plain control or status level or pulse, with no valid/ready handshake. All inputs are synchronous to `clk`, except `ser_in`, which is resynchronized internally.

Top module: `spdif_phase_ctrl`

## Requirements
- R1: An enable code whose low bit is 0 puts the block in idle (`phase` = 00) on the next clock edge from any phase. The same edge clears `sync_err`, the retry count and the activity count. `att_start` stays low in idle.
- R2: From idle, enable code 01 (sync only) or 11 (receive) moves `phase` to 01 (synchronizing) on the next clock edge.
- R3: With `wait_act` clear, the first attempt is launched in the first synchronizing cycle. With `wait_act` set, it is launched only after four transitions of the selected line. Each transition takes two synchronizer stages plus one edge-detect stage to register, and the attempt pulse follows the cycle in which the fourth transition is seen.
- R4: `in_sel` value k selects `ser_in[k]` as the monitored line. Transitions on the other lines have no effect.
- R5: `att_start` is a one-cycle pulse. No new attempt is launched until `att_ok` or `att_fail` arrives. If both arrive in the same cycle, success wins.
- R6: Success while the enable code is 11 moves `phase` to 10 (receiving). On the same edge, `sync_done` pulses for one cycle.
- R7: Success while the enable code is 01 moves `phase` to 11 (synced, holding) and pulses `sync_done`. A later enable code of 11 moves the block from holding to receiving.
- R8: Retry code 00, 01, 10 or 11 allows 0, 3, 15 or 63 retries after the first attempt, giving 1, 4, 16 or 64 attempts in total. After the last allowed failure, `sync_err` sets and stays set. The block then launches no further attempts and stays in `phase` 01 until the enable code goes idle.
- R9: Once receiving, the block never moves to the synchronizing phase directly. Enable code 01 leaves it receiving.
- R10: The reserved enable code 10 behaves exactly like idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_code | input | 2 | Enable code: 00/10 idle, 01 sync only, 11 receive |
| retry_code | input | 2 | Retry budget code: 0, 3, 15 or 63 retries |
| wait_act | input | 1 | Wait for four line transitions before the first attempt |
| in_sel | input | 2 | Monitored line selector |
| ser_in | input | 4 | Asynchronous serial lines |
| att_ok | input | 1 | Attempt succeeded (one-cycle pulse) |
| att_fail | input | 1 | Attempt failed (one-cycle pulse) |
| att_start | output | 1 | Launch one synchronization attempt (one-cycle pulse) |
| phase | output | 2 | 00 idle, 01 synchronizing, 10 receiving, 11 synced holding |
| sync_done | output | 1 | One-cycle pulse when synchronization succeeds |
| sync_err | output | 1 | Sticky flag: the retry budget is exhausted |

## Verification
The bench counts attempt pulses for each retry code. An off-by-one in the budget would show up as 3 or 5 attempts instead of 4, or as an attempt launched after `sync_err` is set. It toggles the unselected lines and then exactly three selected transitions. A design that ignored the selector, or that counted to the wrong number, would launch an attempt early. It drives simultaneous success and failure, tries enable code 01 while receiving, and writes the reserved code 10. A design that got these wrong would show a spurious `sync_err`, a fall back into synchronizing, or a missing return to idle.

// File: rtl/spdif_phase_pkg.sv
package spdif_phase_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_WACT   = 3'd1,
    ST_LAUNCH = 3'd2,
    ST_PEND   = 3'd3,
    ST_FAIL   = 3'd4,
    ST_HOLD   = 3'd5,
    ST_RECV   = 3'd6
  } ctl_state_t;

  localparam logic [1:0] PH_IDLE = 2'b00;
  localparam logic [1:0] PH_SYNC = 2'b01;
  localparam logic [1:0] PH_RECV = 2'b10;
  localparam logic [1:0] PH_HOLD = 2'b11;
endpackage

// File: rtl/spdif_line_monitor.sv
module spdif_line_monitor #(
  parameter int N_IN        = 4,
  parameter int SYNC_STAGES = 2,
  parameter int ACT_EDGES   = 4,
  localparam int SEL_W      = (N_IN > 1) ? $clog2(N_IN) : 1,
  localparam int CNT_W      = $clog2(ACT_EDGES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IN-1:0]  ser_in,
  input  logic [SEL_W-1:0] in_sel,
  input  logic             cnt_en,
  output logic             act_hit
);
  localparam int CHAIN = SYNC_STAGES + 1;

  logic             line_raw;
  logic [CHAIN-1:0] chain;
  logic             edge_seen;
  logic [CNT_W-1:0] act_cnt;

  assign line_raw = ser_in[in_sel];

  genvar g;
  generate
    for (g = 0; g < CHAIN; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= line_raw;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign edge_seen = chain[CHAIN-1] ^ chain[CHAIN-2];
  assign act_hit   = cnt_en && edge_seen && (act_cnt == CNT_W'(ACT_EDGES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               act_cnt <= '0;
    else if (!cnt_en)         act_cnt <= '0;
    else if (edge_seen && !act_hit) act_cnt <= act_cnt + 1'b1;
  end
endmodule

// File: rtl/spdif_retry_budget.sv
module spdif_retry_budget #(
  parameter int CODE_W = 2,
  localparam int CNT_W = 2 * ((1 << CODE_W) - 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              fail_evt,
  input  logic [CODE_W-1:0] code,
  output logic              exhausted
);
  logic [CODE_W:0]  shamt;
  logic [CNT_W:0]   limit_w;
  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] used;

  assign shamt     = {code, 1'b0};
  assign limit_w   = ({{CNT_W{1'b0}}, 1'b1} << shamt) - 1'b1;
  assign limit     = limit_w[CNT_W-1:0];
  assign exhausted = (used == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      used <= '0;
    else if (clr)                    used <= '0;
    else if (fail_evt && !exhausted) used <= used + 1'b1;
  end
endmodule

// File: rtl/spdif_phase_ctrl.sv
module spdif_phase_ctrl
  import spdif_phase_pkg::*;
#(
  parameter int N_IN         = 4,
  parameter int RETRY_CODE_W = 2,
  parameter int ACT_EDGES    = 4,
  parameter int SYNC_STAGES  = 2,
  localparam int SEL_W       = (N_IN > 1) ? $clog2(N_IN) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [1:0]              en_code,
  input  logic [RETRY_CODE_W-1:0] retry_code,
  input  logic                    wait_act,
  input  logic [SEL_W-1:0]        in_sel,
  input  logic [N_IN-1:0]         ser_in,
  input  logic                    att_ok,
  input  logic                    att_fail,
  output logic                    att_start,
  output logic [1:0]              phase,
  output logic                    sync_done,
  output logic                    sync_err
);
  ctl_state_t st, st_nxt;
  logic idle_req, want_recv;
  logic act_hit, exhausted, fail_evt, ok_evt;
  logic done_q, err_q;

  assign idle_req  = !en_code[0];
  assign want_recv = en_code[1];
  assign ok_evt    = (st == ST_PEND) && att_ok && !idle_req;
  assign fail_evt  = (st == ST_PEND) && att_fail && !att_ok && !idle_req;

  spdif_line_monitor #(
    .N_IN(N_IN), .SYNC_STAGES(SYNC_STAGES), .ACT_EDGES(ACT_EDGES)
  ) u_mon (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .in_sel(in_sel),
    .cnt_en((st == ST_WACT) && !idle_req), .act_hit(act_hit)
  );

  spdif_retry_budget #(.CODE_W(RETRY_CODE_W)) u_budget (
    .clk(clk), .rst_n(rst_n), .clr(idle_req), .fail_evt(fail_evt),
    .code(retry_code), .exhausted(exhausted)
  );

  always_comb begin
    st_nxt = st;
    if (idle_req) begin
      st_nxt = ST_IDLE;
    end else begin
      unique case (st)
        ST_IDLE:   st_nxt = wait_act ? ST_WACT : ST_LAUNCH;
        ST_WACT:   if (act_hit) st_nxt = ST_LAUNCH;
        ST_LAUNCH: st_nxt = ST_PEND;
        ST_PEND: begin
          if (ok_evt)        st_nxt = want_recv ? ST_RECV : ST_HOLD;
          else if (fail_evt) st_nxt = exhausted ? ST_FAIL : ST_LAUNCH;
        end
        ST_HOLD:   if (want_recv) st_nxt = ST_RECV;
        ST_FAIL:   st_nxt = ST_FAIL;
        ST_RECV:   st_nxt = ST_RECV;
        default:   st_nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st     <= st_nxt;
      done_q <= ok_evt;
      if (idle_req)                   err_q <= 1'b0;
      else if (fail_evt && exhausted) err_q <= 1'b1;
    end
  end

  always_comb begin
    unique case (st)
      ST_IDLE: phase = PH_IDLE;
      ST_HOLD: phase = PH_HOLD;
      ST_RECV: phase = PH_RECV;
      default: phase = PH_SYNC;
    endcase
  end

  assign att_start = (st == ST_LAUNCH);
  assign sync_done = done_q;
  assign sync_err  = err_q;
endmodule

// File: rtl/spdif_phase_ctrl_chk.sv
module spdif_phase_ctrl_chk
  import spdif_phase_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] en_code,
  input logic       att_start,
  input logic [1:0] phase,
  input logic       sync_done,
  input logic       sync_err
);
  AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (en_code == 2'b00) |=> (phase == PH_IDLE && !sync_err && !att_start)); // R1
  AST_ENTER_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE && en_code[0]) |=> (phase == PH_SYNC)); // R2
  AST_START_IN_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    att_start |-> (phase == PH_SYNC)); // R3
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    att_start |=> !att_start); // R5
  AST_DONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    sync_done |-> (phase == PH_RECV || phase == PH_HOLD)); // R6
  AST_HOLD_TO_RECV: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_HOLD && en_code == 2'b11) |=> (phase == PH_RECV)); // R7
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err |-> (!att_start && phase == PH_SYNC)); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_err && en_code[0]) |=> sync_err); // R8
  AST_NO_RCV_TO_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_RECV) |=> (phase != PH_SYNC)); // R9
  AST_RESERVED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (en_code == 2'b10) |=> (phase == PH_IDLE && !sync_err)); // R10
endmodule

bind spdif_phase_ctrl spdif_phase_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en_code(en_code), .att_start(att_start),
  .phase(phase), .sync_done(sync_done), .sync_err(sync_err)
);

// File: tb/test_spdif_phase_ctrl.sv
module test_spdif_phase_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] en_code = 2'b00;
  logic [1:0] retry_code = 2'b00;
  logic       wait_act = 1'b0;
  logic [1:0] in_sel = 2'b00;
  logic [3:0] ser_in = 4'h0;
  logic       att_ok = 1'b0;
  logic       att_fail = 1'b0;
  logic       att_start;
  logic [1:0] phase;
  logic       sync_done;
  logic       sync_err;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spdif_phase_ctrl i_spdif_phase_ctrl (
    .clk(clk), .rst_n(rst_n), .en_code(en_code), .retry_code(retry_code),
    .wait_act(wait_act), .in_sel(in_sel), .ser_in(ser_in),
    .att_ok(att_ok), .att_fail(att_fail), .att_start(att_start),
    .phase(phase), .sync_done(sync_done), .sync_err(sync_err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model: 0 idle, 1 waiting activity, 2 launching,
  // 3 pending, 4 failed, 5 holding, 6 receiving
  int   m_st = 0;
  int   m_act = 0;
  int   m_tries = 0;
  bit   m_err = 0;
  bit   m_done = 0;
  bit   hist[$] = '{0, 0, 0, 0};

  function automatic int limit_of(input logic [1:0] c);
    case (c)
      2'b00: return 0;
      2'b01: return 3;
      2'b10: return 15;
      default: return 63;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_act = 0; m_tries = 0; m_err = 0; m_done = 0;
      hist = '{0, 0, 0, 0};
    end else begin
      bit edge_now;
      edge_now = (hist[hist.size()-2] != hist[hist.size()-3]);
      hist.push_back(ser_in[in_sel]);
      void'(hist.pop_front());
      m_done = 0;
      if (en_code[0] == 1'b0) begin
        m_st = 0; m_act = 0; m_tries = 0; m_err = 0;
      end else begin
        case (m_st)
          0: begin m_st = wait_act ? 1 : 2; m_act = 0; end
          1: if (edge_now) begin
               m_act++;
               if (m_act == 4) m_st = 2;
             end
          2: m_st = 3;
          3: if (att_ok) begin
               m_st = en_code[1] ? 6 : 5; m_done = 1;
             end else if (att_fail) begin
               if (m_tries == limit_of(retry_code)) begin m_st = 4; m_err = 1; end
               else begin m_tries++; m_st = 2; end
             end
          5: if (en_code[1]) m_st = 6;
          default: ;
        endcase
      end
    end
  end

  function automatic int exp_phase(input int s);
    if (s == 0) return 0;
    if (s == 5) return 3;
    if (s == 6) return 2;
    return 1;
  endfunction

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(phase == exp_phase(m_st), "R2 phase", phase, exp_phase(m_st));
      check(att_start == (m_st == 2), "R3 att_start", att_start, (m_st == 2));
      check(sync_done == m_done, "R6 sync_done", sync_done, m_done);
      check(sync_err == m_err, "R8 sync_err", sync_err, m_err);
    end
  end

  // Synchronizer stand-in
  int  resp_fails = 0;   // failures before success; -1 never succeeds
  bit  resp_both = 0;
  bit  pend = 0;
  int  n_start = 0;

  always @(negedge clk) begin
    att_ok   = 1'b0;
    att_fail = 1'b0;
    if (pend) begin
      pend = 0;
      if (resp_both) begin att_ok = 1'b1; att_fail = 1'b1; end
      else if (resp_fails != 0) begin
        att_fail = 1'b1;
        if (resp_fails > 0) resp_fails--;
      end else att_ok = 1'b1;
    end
    if (att_start) begin pend = 1; n_start++; end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic go_idle();
    @(negedge clk); en_code = 2'b00;
    cyc(3);
  endtask

  task automatic budget_run(input logic [1:0] code, input int exp_att, input string tag);
    int s0;
    go_idle();
    retry_code = code; resp_fails = -1; resp_both = 0; wait_act = 0;
    s0 = n_start;
    @(negedge clk); en_code = 2'b01;
    cyc(2 * exp_att + 20);
    check(n_start - s0 == exp_att, tag, n_start - s0, exp_att);
    check(sync_err == 1'b1, tag, sync_err, 1);
    check(phase == 2'b01, tag, phase, 1);
  endtask

  initial begin
    int s0;
    cyc(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(phase == 2'b00 && !att_start && !sync_err && !sync_done, "R1 reset", phase, 0);

    // R6, R2: straight to receive with no retries
    resp_fails = 0;
    @(negedge clk); en_code = 2'b11;
    @(negedge clk);
    check(phase == 2'b01, "R2 enter sync", phase, 1);
    cyc(6);
    check(phase == 2'b10, "R6 receive", phase, 2);
    // R9: sync-only code while receiving does not fall back
    @(negedge clk); en_code = 2'b01;
    cyc(5);
    check(phase == 2'b10, "R9 stay receive", phase, 2);
    // R1: back to idle
    @(negedge clk); en_code = 2'b00;
    @(negedge clk);
    check(phase == 2'b00, "R1 idle", phase, 0);

    // R7: sync only parks, then receive
    cyc(2);
    resp_fails = 0;
    @(negedge clk); en_code = 2'b01;
    cyc(6);
    check(phase == 2'b11, "R7 hold", phase, 3);
    @(negedge clk); en_code = 2'b11;
    @(negedge clk);
    check(phase == 2'b10, "R7 hold to receive", phase, 2);

    // R8: all four budgets
    budget_run(2'b00, 1, "R8 budget 0");
    budget_run(2'b01, 4, "R8 budget 3");
    // R10: reserved code returns to idle and clears the error
    @(negedge clk); en_code = 2'b10;
    @(negedge clk);
    check(phase == 2'b00 && !sync_err, "R10 reserved idle", {sync_err, phase}, 0);
    budget_run(2'b10, 16, "R8 budget 15");
    budget_run(2'b11, 64, "R8 budget 63");

    // R8: two failures then success stays clean
    go_idle();
    retry_code = 2'b01; resp_fails = 2;
    s0 = n_start;
    @(negedge clk); en_code = 2'b11;
    cyc(20);
    check(n_start - s0 == 3 && phase == 2'b10 && !sync_err, "R8 late success", n_start - s0, 3);

    // R5: success and failure together
    go_idle();
    retry_code = 2'b00; resp_both = 1;
    @(negedge clk); en_code = 2'b11;
    cyc(8);
    check(phase == 2'b10 && !sync_err, "R5 ok wins", phase, 2);
    resp_both = 0;

    // R3, R4: activity wait on line 2
    go_idle();
    resp_fails = 0; wait_act = 1; in_sel = 2'd2;
    s0 = n_start;
    @(negedge clk); en_code = 2'b11;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); ser_in[0] = ~ser_in[0]; ser_in[1] = ~ser_in[1]; ser_in[3] = ~ser_in[3];
      cyc(1);
    end
    cyc(4);
    check(n_start == s0 && phase == 2'b01, "R4 other lines ignored", n_start - s0, 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); ser_in[2] = ~ser_in[2];
      cyc(2);
    end
    cyc(4);
    check(n_start == s0, "R3 three transitions", n_start - s0, 0);
    @(negedge clk); ser_in[2] = ~ser_in[2];
    cyc(8);
    check(n_start - s0 == 1 && phase == 2'b10, "R3 fourth transition", n_start - s0, 1);

    // R3: no wait launches at once
    go_idle();
    wait_act = 0; resp_fails = 0;
    s0 = n_start;
    @(negedge clk); en_code = 2'b01;
    @(negedge clk);
    check(att_start == 1'b1, "R3 immediate", att_start, 1);
    cyc(4);
    go_idle();

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule